// File: doc/BRIEF.md
# Serial-Bus Peripheral Interrupt Pending and Priority Unit

This block gathers the event sources of a serial-bus peripheral and of the DMA engine that serves it. It turns them into one prioritized service request for the CPU interrupt controller. The two data events and the two DMA end-of-block events each latch a pending bit. That bit stays set until software clears it. The error pending bit is not latched: it follows the OR of nine error flags, one cycle later.

The pending bits are masked and ranked. The error source comes first, then DMA service, then the receive group, then the transmit group. The block presents a request line and a two-bit vector selection. The receive end-of-block source shares the receive vector, and the transmit end-of-block source shares the transmit vector. The end-of-block sources ignore the global interrupt enable, and they do not raise the general event flag.

Top module: `irq_pending_unit`

## Requirements
- R1: The pending bits are data received, ready to transmit, receive end-of-block and transmit end-of-block. Each is set on the clock edge after its event input is high. It then stays set until software clears it. While a pending bit is set and enabled, the request stays asserted.
- R2: `clr_bits` bit 0 clears data received, bit 1 ready to transmit, bit 2 receive end-of-block and bit 3 transmit end-of-block. A clear takes effect on the edge after the cycle in which it is presented. When an event and a clear for the same bit occur in the same cycle, the bit stays set.
- R3: The error pending bit is the OR of all `err_flags` bits, registered once. Software cannot clear it.
- R4: The vector codes are 0 for error, 1 for DMA service, 2 for receive and 3 for transmit. When several codes are active, the lowest code wins. When nothing is active, `irq_req` is 0 and `irq_vec` is 0.
- R5: The `status` bit order is: bit 0 error, bit 1 data received, bit 2 ready to transmit, bit 3 receive end-of-block, bit 4 transmit end-of-block. Receive end-of-block raises vector 2 and transmit end-of-block raises vector 3. When a data event and its end-of-block partner are pending together, one request is raised on the shared vector and both status bits stay set.
- R6: `gie` gates the error, data-received and ready-to-transmit sources. It does not gate the two end-of-block sources.
- R7: `evt_flag` is high exactly when error, data received or ready to transmit is pending. The end-of-block bits never raise it.
- R8: `mask` uses the same bit order as `status`. A source whose mask bit is 0 stays visible in `status` but raises no request.
- R9: DMA service (vector 1) is active while, for either direction, both the `dma_req` bit and the `dma_en` bit are set. Bit 0 is receive and bit 1 is transmit. Nothing is latched for DMA service.
- R10: After reset, `status`, `evt_flag` and `irq_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_flags | input | NERR | Level error conditions of the bus engine |
| rx_evt | input | 1 | Data-received event pulse |
| tx_evt | input | 1 | Ready-to-transmit event pulse |
| rx_eob | input | 1 | Receive DMA block-complete pulse |
| tx_eob | input | 1 | Transmit DMA block-complete pulse |
| mask | input | 5 | Per-source enable, same order as status |
| gie | input | 1 | Global enable for non-block-complete sources |
| dma_req | input | 2 | DMA service wanted (bit0 rx, bit1 tx) |
| dma_en | input | 2 | DMA enable per direction |
| clr_bits | input | 4 | Software clear strobes for the latched bits |
| irq_req | output | 1 | Prioritized service request |
| irq_vec | output | 2 | Selected vector code |
| status | output | 5 | Pending bits |
| evt_flag | output | 1 | General event flag |

## Verification
Two functions can fall in the same cycle: a software clear and a fresh event on the same pending bit. The bench makes this happen by pulsing the transmit-ready event in the very cycle that clears it, and requires the bit to survive. It also sets a data pending bit while its end-of-block partner is pending on the same vector, and requires a single request with both status bits set until each is cleared on its own.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 5;
    localparam int NLAT  = 4;
    localparam int NGRP  = 4;
    localparam int S_ERR = 0;
    localparam int S_RX  = 1;
    localparam int S_TX  = 2;
    localparam int S_RXB = 3;
    localparam int S_TXB = 4;

    typedef enum logic [1:0] {
        VEC_ERR = 2'd0,
        VEC_DMA = 2'd1,
        VEC_RX  = 2'd2,
        VEC_TX  = 2'd3
    } vec_e;
endpackage

// File: rtl/pend_bank.sv
module pend_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            st_d.pend[i] = set_i[i] | (st_q.pend[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2
        evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]);
        // R1
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
        // R2
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
    end
endmodule

// File: rtl/prio_arb.sv
module prio_arb #(
    parameter int N = 4,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  act_i,
    output logic          req_o,
    output logic [SW-1:0] sel_o,
    output logic [N-1:0]  gnt_o
);
    always_comb begin
        gnt_o = '0;
        sel_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                sel_o    = SW'(i);
            end
        end
        req_o = |act_i;
    end

    // R4
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    // R4
    top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i[0] |-> (sel_o == '0));
    // R4
    sel_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> act_i[sel_o]);
endmodule

// File: rtl/irq_pending_unit.sv
module irq_pending_unit
    import irq_pkg::*;
#(
    parameter int NERR = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NERR-1:0] err_flags,
    input  logic            rx_evt,
    input  logic            tx_evt,
    input  logic            rx_eob,
    input  logic            tx_eob,
    input  logic [NSRC-1:0] mask,
    input  logic            gie,
    input  logic [1:0]      dma_req,
    input  logic [1:0]      dma_en,
    input  logic [NLAT-1:0] clr_bits,
    output logic            irq_req,
    output logic [1:0]      irq_vec,
    output logic [NSRC-1:0] status,
    output logic            evt_flag
);
    typedef struct packed {
        logic err;
    } top_t;

    top_t st_d, st_q;
    logic [NLAT-1:0] pend;
    logic [NGRP-1:0] act;
    logic [NGRP-1:0] gnt;
    logic [1:0]      sel;

    always_comb begin
        st_d     = st_q;
        st_d.err = |err_flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pend_bank #(.N(NLAT)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({tx_eob, rx_eob, tx_evt, rx_evt}),
        .clr_i  (clr_bits),
        .pend_o (pend)
    );

    assign status = {pend, st_q.err};

    always_comb begin
        act[VEC_ERR] = status[S_ERR] & mask[S_ERR] & gie;
        act[VEC_DMA] = |(dma_req & dma_en);
        act[VEC_RX]  = (status[S_RX] & mask[S_RX] & gie) | (status[S_RXB] & mask[S_RXB]);
        act[VEC_TX]  = (status[S_TX] & mask[S_TX] & gie) | (status[S_TXB] & mask[S_TXB]);
    end

    prio_arb #(.N(NGRP)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .req_o (irq_req),
        .sel_o (sel),
        .gnt_o (gnt)
    );

    assign irq_vec  = sel;
    assign evt_flag = status[S_ERR] | status[S_RX] | status[S_TX];

    // R3
    err_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_flags) |=> status[S_ERR]);
    // R3
    err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|err_flags) |=> !status[S_ERR]);
    // R6
    eob_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gie && ((status[S_RXB] && mask[S_RXB]) || (status[S_TXB] && mask[S_TXB]))) |-> irq_req);
    // R7
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[S_TX:S_ERR] == '0) |-> !evt_flag);
    // R8
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && (dma_req & dma_en) == 2'b00) |-> !irq_req);
    // R4
    gnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> gnt[irq_vec]);
endmodule

// File: tb/tb_irq_pending_unit.sv
module tb_irq_pending_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] err_flags = '0;
    logic       rx_evt = 0, tx_evt = 0, rx_eob = 0, tx_eob = 0;
    logic [4:0] mask = 5'h1F;
    logic       gie = 1'b1;
    logic [1:0] dma_req = '0, dma_en = '0;
    logic [3:0] clr_bits = '0;
    logic       irq_req;
    logic [1:0] irq_vec;
    logic [4:0] status;
    logic       evt_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic       req;
        logic [1:0] vec;
        logic [4:0] stat;
        logic       evt;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    irq_pending_unit dut (
        .clk(clk), .rst_n(rst_n), .err_flags(err_flags),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .rx_eob(rx_eob), .tx_eob(tx_eob),
        .mask(mask), .gie(gie), .dma_req(dma_req), .dma_en(dma_en),
        .clr_bits(clr_bits), .irq_req(irq_req), .irq_vec(irq_vec),
        .status(status), .evt_flag(evt_flag)
    );

    task automatic step(input logic [8:0] ef, input logic [3:0] ev, input logic [4:0] mk,
                        input logic g, input logic [1:0] dq, input logic [1:0] de,
                        input logic [3:0] cl, input logic e_req, input logic [1:0] e_vec,
                        input logic [4:0] e_stat, input logic e_evt, input string tag);
        exp_t e;
        @(negedge clk);
        err_flags = ef;
        {tx_eob, rx_eob, tx_evt, rx_evt} = ev;
        mask = mk; gie = g; dma_req = dq; dma_en = de; clr_bits = cl;
        e.req = e_req; e.vec = e_vec; e.stat = e_stat; e.evt = e_evt; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (irq_req !== e.req || irq_vec !== e.vec || status !== e.stat || evt_flag !== e.evt) begin
                n_fail++;
                $display("FAIL %s: req/vec/stat/evt got %b/%0d/%b/%b exp %b/%0d/%b/%b",
                         e.tag, irq_req, irq_vec, status, evt_flag, e.req, e.vec, e.stat, e.evt);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (status !== 5'b0 || irq_req !== 1'b0 || evt_flag !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 reset: stat/req/evt got %b/%b/%b exp 00000/0/0", status, irq_req, evt_flag);
        end
        @(negedge clk) rst_n = 1'b1;
        //   errf   ev{txb,rxb,tx,rx} mask gie dq de clr  req vec stat evt
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b00, 2'b00, 4'b0000, 0, 0, 5'b00000, 0, "R10 idle");
        step(9'h0, 4'b0001, 5'h1F, 1, 2'b00, 2'b00, 4'b0000, 1, 2, 5'b00010, 1, "R1 rx set");
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b00, 2'b00, 4'b0000, 1, 2, 5'b00010, 1, "R1 rx held");
        step(9'h0, 4'b0010, 5'h1F, 1, 2'b00, 2'b00, 4'b0000, 1, 2, 5'b00110, 1, "R4 rx over tx");
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b00, 2'b00, 4'b0001, 1, 3, 5'b00100, 1, "R2 rx clear");
        step(9'h0, 4'b0010, 5'h1F, 1, 2'b00, 2'b00, 4'b0010, 1, 3, 5'b00100, 1, "R2 event beats clear");
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b00, 2'b00, 4'b0010, 0, 0, 5'b00000, 0, "R2 tx clear");
        step(9'h0, 4'b0100, 5'h1F, 0, 2'b00, 2'b00, 4'b0000, 1, 2, 5'b01000, 0, "R6 R7 rx eob no gie");
        step(9'h0, 4'b0001, 5'h1F, 0, 2'b00, 2'b00, 4'b0000, 1, 2, 5'b01010, 1, "R5 shared vector");
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b00, 2'b00, 4'b0100, 1, 2, 5'b00010, 1, "R5 separate clear");
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b01, 2'b01, 4'b0000, 1, 1, 5'b00010, 1, "R9 R4 dma over rx");
        step(9'h100, 4'b0000, 5'h1F, 1, 2'b01, 2'b01, 4'b0000, 1, 0, 5'b00011, 1, "R3 R4 err over dma");
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b00, 2'b00, 4'b0001, 0, 0, 5'b00000, 0, "R3 err follows flags");
        step(9'h0, 4'b0001, 5'h00, 1, 2'b00, 2'b00, 4'b0000, 0, 0, 5'b00010, 1, "R8 masked rx");
        step(9'h0, 4'b0000, 5'h1F, 0, 2'b00, 2'b00, 4'b0000, 0, 0, 5'b00010, 1, "R6 gie gates rx");
        step(9'h0, 4'b0010, 5'h1F, 1, 2'b10, 2'b01, 4'b0000, 1, 2, 5'b00110, 1, "R9 dma dir mismatch");
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b10, 2'b10, 4'b0011, 1, 1, 5'b00000, 0, "R9 tx dma");
        step(9'h0, 4'b1000, 5'h1F, 0, 2'b00, 2'b00, 4'b0000, 1, 3, 5'b10000, 0, "R5 R6 tx eob vector");
        step(9'h001, 4'b0000, 5'h1E, 1, 2'b00, 2'b00, 4'b1000, 0, 0, 5'b00001, 1, "R8 R3 err masked");
        step(9'h0, 4'b0000, 5'h1F, 1, 2'b00, 2'b00, 4'b0000, 0, 0, 5'b00000, 0, "R3 err drop");
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule